// File: doc/BRIEF.md
# Frame Status Queue for a Bit-Oriented Receiver

This block sits behind a bit-oriented (HDLC-style) serial receiver and keeps the end-of-frame results of recent frames, so that a CPU can check the integrity of each frame some time after the frame has ended. A 14-bit counter counts the received bytes of the current frame. When the frame closes, either with a closing flag or with an abort, the count and the frame's queued status bits form one entry of a ten-entry queue. The counter then clears, and a CRC-reset strobe goes out so that the next frame can begin at once.

The CPU reads results through a small read port with three addresses: count high, count low and status. A read sequence starts at count high, which returns a data-available flag and latches the source for the rest of the sequence. Count low is optional. The status read ends the sequence and removes exactly one entry. Only the residue code, receive overrun and CRC error are queued. All-sent, parity and end-of-frame are always taken live. The queue works only while the enable input is high and the channel is in bit-oriented mode. In any other state every address returns the live status byte and nothing is queued.

Top module: `hdlc_frm_stat_q`

## Requirements
- R1: Each `rx_byte` strobe increments the frame byte counter. A strobe in the same cycle as the frame end is included in the stored count. The count-low read (address 1) returns count bits 7:0 of the head entry.
- R2: The status byte has this layout: bit 0 all-sent, bits 3:1 residue code, bit 4 parity, bit 5 receive overrun, bit 6 CRC error, bit 7 end-of-frame. A status read (address 0) from the queue takes bits 6, 5 and 3:1 from the head entry and bits 7, 4 and 0 from the live inputs.
- R3: The queue holds ten entries. A frame end that arrives while ten entries are held is dropped and sets a sticky overrun flag. The flag is read at bit 7 of count high and is cleared only by `chan_rst` or `rst_n`.
- R4: A frame ended by `rx_abort` pushes its count and status in the same way as `rx_eof` does.
- R5: In the cycle after any frame end, `crc_reset` is 1 for one cycle, and the next frame counts from zero.
- R6: The queue is active only when `fifo_en` and `sdlc_mode` are both 1. When it is not active, addresses 0, 1 and 2 all return the live status byte and frame ends push nothing. Address 3 always reads 0.
- R7: The queue is emptied when it becomes inactive, on `chan_rst`, and on `rst_n`.
- R8: The count-high read (address 2) returns {overrun flag, data-available, count bits 13:8}. Data-available is 1 when the queue is not empty. This read latches data-available as the source selection for the sequence.
- R9: Only a status read that follows a count-high read which saw data removes an entry. A second status read in the same sequence, or a status read with no count-high read before it, returns the live status byte and removes nothing.
- R10: When the queue is empty, count high returns data-available 0 with a zero count, and the status read returns the live status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| fifo_en | input | 1 | Queue enable |
| sdlc_mode | input | 1 | Channel is in bit-oriented framing mode |
| rx_byte | input | 1 | One received byte of the current frame |
| rx_eof | input | 1 | Closing flag seen, frame ends |
| rx_abort | input | 1 | Abort seen, frame ends |
| live_resid | input | 3 | Live residue code |
| live_ovr | input | 1 | Live receive overrun |
| live_crc_err | input | 1 | Live CRC error |
| live_all_sent | input | 1 | Live all-sent bit |
| live_parity | input | 1 | Live parity error |
| live_eof | input | 1 | Live end-of-frame bit |
| rd_en | input | 1 | CPU read strobe, side effects at the clock edge |
| rd_addr | input | 2 | Read address: 0 status, 1 count low, 2 count high |
| rd_data | output | 8 | Read data, combinational from address and state |
| crc_reset | output | 1 | One-cycle strobe after each frame end |

## Verification
Assertions check the following on every cycle: the queue level never goes past ten, a dropped push leaves the queue full and the overrun flag set, a pop never happens on an empty queue, two pops never come in back-to-back cycles, a flush leaves the queue empty, and every frame end is followed by the CRC strobe with the counter at zero. Other behaviour can be shown only by the bench's scenarios. These are the first-in first-out order of counts and status across fills from zero to eleven frames, the merge of live and queued status bits in the read byte, the fixed read order with its single pop, and the fall-back to live status when the queue is disabled or empty.

// File: rtl/frm_stat_pkg.sv
// Shared types for the frame status queue: read addresses, queued status
// fields and the packing of the status byte seen by the CPU.
package frm_stat_pkg;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_CLO  = 2'd1,
        ADDR_CHI  = 2'd2,
        ADDR_NONE = 2'd3
    } rd_addr_e;

    // Status fields that travel through the queue with each frame.
    typedef struct packed {
        logic       crc_err;
        logic       rx_ovr;
        logic [2:0] resid;
    } qstat_t;

    localparam int QSTAT_W = $bits(qstat_t);

    // Build the CPU status byte from live bits and queued fields.
    function automatic logic [7:0] status_byte(input logic all_sent,
                                               input logic parity,
                                               input logic eof,
                                               input qstat_t q);
        return {eof, q.crc_err, q.rx_ovr, parity, q.resid, all_sent};
    endfunction

endpackage

// File: rtl/frm_byte_cnt.sv
// Per-frame byte counter.
// Counts rx_byte strobes and clears at every frame end, whether the queue is
// active or not. frame_cnt already includes a strobe that coincides with the
// end. crc_reset pulses in the cycle after each end.
// Assumes frame_end and rx_byte are single-cycle strobes in the clk domain.
module frm_byte_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_rst,
    input  logic             rx_byte,
    input  logic             frame_end,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             crc_reset
);

    logic [CNT_W-1:0] cnt_q;

    assign frame_cnt = cnt_q + CNT_W'(rx_byte);

    // Hold the running byte count of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)  cnt_q <= '0;
        else if (frame_end)      cnt_q <= '0;
        else if (rx_byte)        cnt_q <= frame_cnt;
    end

    // Issue a one-cycle CRC reset after each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) crc_reset <= 1'b0;
        else                    crc_reset <= frame_end;
    end

    // R5: the counter is zero whenever the CRC strobe is out
    a_r5_cnt_zero_on_crc: assert property (@(posedge clk) disable iff (!rst_n)
        crc_reset |-> (cnt_q == '0));

    // R1: a lone byte strobe advances the count by one
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte && !frame_end && !chan_rst) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/stat_fifo.sv
// Circular queue of frame results with a depth that need not be a power of two.
// A push into a full queue is dropped and sets a sticky overrun flag. flush
// empties the queue. sticky_clr clears only the overrun flag.
// Assumes pop is asserted only by the read port, and a pop on empty is ignored.
module stat_fifo #(
    parameter int DEPTH = 10,
    parameter int W     = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         sticky_clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf_flag
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level;
    logic          full, do_push, do_pop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rd_ptr];

    // Store a pushed entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Move pointers and level, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Keep the sticky overrun flag until a channel or power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sticky_clr)             ovf_flag <= 1'b0;
        else if (push && !flush && !do_push)  ovf_flag <= 1'b1;
    end

    // R3: occupancy never exceeds the depth
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R3: a push into a full queue leaves it full and flags overrun
    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush && !sticky_clr) |=> (full && ovf_flag));

    // R10: the read port never pops an empty queue
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R7: a flush leaves the queue empty
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/stat_rd_port.sv
// CPU read port: sequences count-high, count-low, status reads and steers
// each read to the queue head or to the live status.
// The count-high read latches whether data was available. Only a status read
// after such a latch pops, and that read also clears the latch.
// Assumes at most one read per cycle and CNT_W between 9 and 14.
module stat_rd_port
    import frm_stat_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             active,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] head_cnt,
    input  qstat_t           head_stat,
    input  logic             ovf_flag,
    input  qstat_t           live_stat,
    input  logic             live_all_sent,
    input  logic             live_parity,
    input  logic             live_eof,
    output logic [7:0]       rd_data,
    output logic             pop
);

    localparam int HI_W = CNT_W - 8;

    logic       sel_q;
    logic       avail;
    logic [7:0] live_byte;
    logic [7:0] head_byte;
    logic       rd_chi, rd_stat;

    assign avail     = !fifo_empty;
    assign live_byte = status_byte(live_all_sent, live_parity, live_eof, live_stat);
    assign head_byte = status_byte(live_all_sent, live_parity, live_eof, head_stat);
    assign rd_chi    = rd_en && (rd_addr_e'(rd_addr) == ADDR_CHI);
    assign rd_stat   = rd_en && (rd_addr_e'(rd_addr) == ADDR_STAT);
    assign pop       = rd_stat && sel_q && active;

    // Latch the source selection on count-high and release it on status.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)      sel_q <= 1'b0;
        else if (rd_chi)          sel_q <= avail;
        else if (rd_stat)         sel_q <= 1'b0;
    end

    // Select read data for the addressed register.
    always_comb begin
        rd_data = 8'h00;
        if (!active) begin
            if (rd_addr_e'(rd_addr) != ADDR_NONE) rd_data = live_byte;
        end else begin
            case (rd_addr_e'(rd_addr))
                ADDR_STAT: rd_data = sel_q ? head_byte : live_byte;
                ADDR_CLO:  rd_data = sel_q ? head_cnt[7:0] : 8'h00;
                ADDR_CHI:  rd_data = {ovf_flag, avail,
                                      avail ? 6'(head_cnt[CNT_W-1:CNT_W-HI_W]) : 6'd0};
                default:   rd_data = 8'h00;
            endcase
        end
    end

    // R9: at most one pop per read sequence
    a_r9_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);

    // R8: the count-high read latches the data-available state
    a_r8_latch_avail: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chi && !flush) |=> (sel_q == $past(avail)));

endmodule

// File: rtl/hdlc_frm_stat_q.sv
// Frame status queue top level.
// Joins the byte counter, the result queue and the CPU read port. The queue
// is active only in bit-oriented mode with the enable set. It is flushed
// while inactive and on channel reset.
// Assumes all inputs are synchronous to clk.
module hdlc_frm_stat_q
    import frm_stat_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int DEPTH = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_rst,
    input  logic       fifo_en,
    input  logic       sdlc_mode,
    input  logic       rx_byte,
    input  logic       rx_eof,
    input  logic       rx_abort,
    input  logic [2:0] live_resid,
    input  logic       live_ovr,
    input  logic       live_crc_err,
    input  logic       live_all_sent,
    input  logic       live_parity,
    input  logic       live_eof,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       crc_reset
);

    localparam int ENT_W = CNT_W + QSTAT_W;

    logic             active, flush, frame_end, push, pop;
    logic             fifo_empty, ovf_flag;
    logic [CNT_W-1:0] frame_cnt;
    logic [ENT_W-1:0] head;
    qstat_t           live_stat;

    assign active    = fifo_en && sdlc_mode;
    assign flush     = chan_rst || !active;
    assign frame_end = rx_eof || rx_abort;
    assign push      = frame_end && active;
    assign live_stat = '{crc_err: live_crc_err, rx_ovr: live_ovr, resid: live_resid};

    frm_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_rst  (chan_rst),
        .rx_byte   (rx_byte),
        .frame_end (frame_end),
        .frame_cnt (frame_cnt),
        .crc_reset (crc_reset)
    );

    stat_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .sticky_clr (chan_rst),
        .push       (push),
        .pop        (pop),
        .wdata      ({live_stat, frame_cnt}),
        .rdata      (head),
        .empty      (fifo_empty),
        .ovf_flag   (ovf_flag)
    );

    stat_rd_port #(.CNT_W(CNT_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .active        (active),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .fifo_empty    (fifo_empty),
        .head_cnt      (head[CNT_W-1:0]),
        .head_stat     (qstat_t'(head[ENT_W-1:CNT_W])),
        .ovf_flag      (ovf_flag),
        .live_stat     (live_stat),
        .live_all_sent (live_all_sent),
        .live_parity   (live_parity),
        .live_eof      (live_eof),
        .rd_data       (rd_data),
        .pop           (pop)
    );

    // R5 / R4: every frame end, flag or abort, is followed by the CRC strobe
    a_r5_crc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !chan_rst) |=> crc_reset);

    // R6: an inactive queue never pops
    a_r6_no_pop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !pop);

endmodule

// File: tb/hdlc_frm_stat_q_bench.sv
module hdlc_frm_stat_q_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LIVE = 8'hCB; // eof=1 crc=1 ovr=0 par=0 resid=5 all=1

    logic       clk = 1'b0;
    logic       rst_n, chan_rst, fifo_en, sdlc_mode;
    logic       rx_byte, rx_eof, rx_abort;
    logic [2:0] live_resid;
    logic       live_ovr, live_crc_err, live_all_sent, live_parity, live_eof;
    logic       rd_en;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       crc_reset;

    int n_chk = 0;
    int n_fail = 0;
    int q_cnt[$];
    logic [4:0] q_st[$];
    logic exp_ovf;
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_frm_stat_q u_hdlc_frm_stat_q (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .fifo_en(fifo_en),
        .sdlc_mode(sdlc_mode), .rx_byte(rx_byte), .rx_eof(rx_eof),
        .rx_abort(rx_abort), .live_resid(live_resid), .live_ovr(live_ovr),
        .live_crc_err(live_crc_err), .live_all_sent(live_all_sent),
        .live_parity(live_parity), .live_eof(live_eof), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .crc_reset(crc_reset)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_live_read();
        live_resid = 3'd5; live_ovr = 1'b0; live_crc_err = 1'b1;
        live_all_sent = 1'b1; live_parity = 1'b0; live_eof = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic pulse_chan_rst();
        @(negedge clk); chan_rst = 1'b1;
        @(negedge clk); chan_rst = 1'b0;
        q_cnt.delete(); q_st.delete(); exp_ovf = 1'b0;
    endtask

    // Send a frame of n bytes; merge puts the last byte on the end cycle.
    task automatic send_frame(input int n, input bit abort, input bit merge,
                              input logic [4:0] st);
        bit act;
        int sep;
        sep = merge ? n - 1 : n;
        for (int k = 0; k < sep; k++) begin
            @(negedge clk); rx_byte = 1'b1;
        end
        @(negedge clk);
        rx_byte = merge;
        if (abort) rx_abort = 1'b1; else rx_eof = 1'b1;
        live_crc_err = st[4]; live_ovr = st[3]; live_resid = st[2:0];
        act = fifo_en && sdlc_mode;
        @(posedge clk);
        #1 rx_byte = 1'b0; rx_eof = 1'b0; rx_abort = 1'b0;
        set_live_read();
        chk(abort ? "R4 crc_reset after abort" : "R5 crc_reset after flag",
            {7'd0, crc_reset}, 8'h01);
        if (act) begin
            if (q_cnt.size() < 10) begin
                q_cnt.push_back(n); q_st.push_back(st);
            end else begin
                exp_ovf = 1'b1;
            end
        end
    endtask

    task automatic drain_one();
        rd(2'd2, d);
        chk("R8 count high", d, {exp_ovf, 1'b1, 6'(q_cnt[0] >> 8)});
        rd(2'd1, d);
        chk("R1 count low", d, 8'(q_cnt[0]));
        rd(2'd0, d);
        chk("R2 queued status", d, {1'b1, q_st[0][4], q_st[0][3], 1'b0, q_st[0][2:0], 1'b1});
        rd(2'd0, d);
        chk("R9 repeat status read is live", d, LIVE);
        void'(q_cnt.pop_front());
        void'(q_st.pop_front());
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; chan_rst = 1'b0; fifo_en = 1'b0; sdlc_mode = 1'b0;
        rx_byte = 1'b0; rx_eof = 1'b0; rx_abort = 1'b0; rd_en = 1'b0; rd_addr = 2'd0;
        exp_ovf = 1'b0;
        set_live_read();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: after reset the queue is inactive, reads show live status
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), d); chk("R6 inactive read", d, LIVE);
        end
        rd(2'd3, d); chk("R6 unused address", d, 8'h00);

        fifo_en = 1'b1; sdlc_mode = 1'b1;
        rd(2'd2, d); chk("R10 empty count high", d, 8'h00);
        rd(2'd0, d); chk("R10 empty status", d, LIVE);

        // Sweep of fill levels from empty to one past full
        for (int nf = 0; nf <= 11; nf++) begin
            pulse_chan_rst();
            for (int i = 0; i < nf; i++)
                send_frame(((i * 113 + nf * 7) % 700) + 1, (i % 3) == 1, (i % 2) == 1,
                           5'((i * 7 + nf) % 32));
            if (nf == 4) begin
                rd(2'd0, d); chk("R9 status without count high", d, LIVE);
            end
            while (q_cnt.size() > 0) drain_one();
            rd(2'd2, d); chk("R10 drained count high", d, {exp_ovf, 7'd0});
            rd(2'd0, d); chk("R10 drained status", d, LIVE);
        end

        // R3: sticky overrun cleared by channel reset
        pulse_chan_rst();
        rd(2'd2, d); chk("R3 overrun cleared", d, 8'h00);

        // R6: frames while disabled or not in bit-oriented mode are not queued
        fifo_en = 1'b0;
        send_frame(5, 1'b0, 1'b0, 5'h1F);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), d); chk("R6 disabled read", d, LIVE);
        end
        fifo_en = 1'b1;
        rd(2'd2, d); chk("R6 no push when disabled", d, 8'h00);
        sdlc_mode = 1'b0;
        send_frame(3, 1'b1, 1'b1, 5'h0A);
        sdlc_mode = 1'b1;
        rd(2'd2, d); chk("R6 no push outside mode", d, 8'h00);

        // R5: counter restarts from zero after the ignored frames
        send_frame(2, 1'b0, 1'b0, 5'h03);
        drain_one();

        // R7: disabling flushes held entries
        for (int i = 0; i < 3; i++) send_frame(i + 1, 1'b0, 1'b0, 5'h11);
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk); fifo_en = 1'b1;
        q_cnt.delete(); q_st.delete();
        rd(2'd2, d); chk("R7 flush on disable", d, 8'h00);

        // R7: channel reset flushes
        send_frame(4, 1'b0, 1'b1, 5'h02);
        pulse_chan_rst();
        rd(2'd2, d); chk("R7 flush on channel reset", d, 8'h00);

        // R7: power-on reset flushes
        send_frame(4, 1'b1, 1'b0, 5'h04);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        q_cnt.delete(); q_st.delete();
        rd(2'd2, d); chk("R7 flush on power-on reset", d, 8'h00);

        finish_run();
    end

endmodule